// File: doc/BRIEF.md
# I/O Channel Command Sequencer with Response Timeout

This block is the channel-side controller for one programmed-I/O transfer to an attached device. A request carries a direction, an 8-bit device number, an 8-bit command and, on writes, a data word. The sequencer drives the address bus, and on writes the outbound data bus. It holds the buses for a minimum settling time and then raises the address gate. It then waits for the device to answer on the gate-return line.

If the device answers in time, the sequencer captures the condition code and, on reads, the inbound data. It pulses the data strobe and drops the gate. It keeps the buses driven until the device withdraws its gate return, then releases them and pulses done.

If no answer arrives within the response window, the device is taken as absent. The sequencer returns condition code 0, drops the gate while the buses are still driven, releases the buses one cycle later and pulses done. No strobe is issued in this case. A new request is accepted only when the sequencer is idle.

Top module: `io_cmd_sequencer`

## Requirements
- R1: The address bus carries `{cmd, device}` (command in bits 15:8, device number in bits 7:0), and `bus_sel_o` is high, from the cycle after an accepted start until the end of teardown; when deselected the bus reads zero.
- R2: The address gate rises only after the buses have been valid for DESKEW_CYC cycles, where DESKEW_CYC = ceil(DESKEW_NS / CLK_PERIOD_NS).
- R3: The gate waits at most TIMEOUT_CYC cycles for gate return, where TIMEOUT_CYC = ceil(RESP_LIMIT_NS / CLK_PERIOD_NS) + TIMEOUT_MARGIN_CYC. A return seen in the last waiting cycle still counts as an answer.
- R4: After a timeout, `cc_o` is 0 (device not attached) and `rdata_o` is 0 when done pulses.
- R5: After a timeout, the strobe is never raised, and the gate is low for one cycle while the buses are still driven before they are released.
- R6: On an answer, `cc_o` takes the value of `cc_in_i` in the cycle the return is seen. `rdata_o` takes `rdata_in_i` on reads and is 0 on writes.
- R7: After an answer, the strobe is high for exactly STROBE_CYC cycles, with the gate held high alongside it.
- R8: After the strobe, the gate drops, and the buses stay driven until gate return is seen low.
- R9: `done_o` is a one-cycle pulse in the cycle after the buses are released, and `cc_o`/`rdata_o` hold the result while it is high.
- R10: A start while a sequence is in progress is ignored: it changes neither the timeline nor the values on the bus.
- R11: After reset all device-side outputs and `done_o`, `cc_o` and `rdata_o` are low.
- R12: The outbound data bus is enabled and carries the write word only during write sequences while selected. It is otherwise disabled and zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Request to begin a sequence |
| write_i | input | 1 | 1 = write sequence, 0 = read sequence |
| dev_addr_i | input | 8 | Target device number |
| cmd_i | input | 8 | Command code |
| wdata_i | input | 16 | Word to send on writes |
| done_o | output | 1 | One-cycle end-of-sequence pulse |
| cc_o | output | 3 | Resulting condition code |
| rdata_o | output | 16 | Word returned by a read |
| bus_addr_o | output | 16 | Address bus `{cmd, device}` |
| bus_sel_o | output | 1 | Address-valid / select line |
| bus_wdata_o | output | 16 | Outbound data bus |
| bus_wdata_oe_o | output | 1 | Outbound data bus enable |
| gate_o | output | 1 | Address gate |
| gate_ret_i | input | 1 | Gate return from device |
| strobe_o | output | 1 | Data strobe |
| cc_in_i | input | 3 | Condition code from device |
| rdata_in_i | input | 16 | Read data from device |

## Verification
The bench uses the default 8 ns clock period. That gives a 25-cycle deskew, a 379-cycle response window and a 3-cycle strobe. It recomputes these counts from the nanosecond figures by its own loop, so an answer in the final waiting cycle and one a single cycle too late are both within reach in a short run. Its device model answers after a chosen delay and withdraws gate return after a chosen hold. Every cycle of every sequence is compared against a timeline derived from those delays, including a stray start injected mid-sequence.

// File: rtl/io_seq_pkg.sv
package io_seq_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_SETUP,
    ST_GATE,
    ST_STROBE,
    ST_RELEASE,
    ST_ABORT,
    ST_FINISH
  } seq_state_t;

  // Whole cycles needed to cover a span given in nanoseconds (rounded up).
  function automatic int ns_to_cycles(input int span_ns, input int period_ns);
    return (span_ns + period_ns - 1) / period_ns;
  endfunction

  function automatic int max3(input int a, input int b, input int c);
    int m;
    m = (a > b) ? a : b;
    return (m > c) ? m : c;
  endfunction

endpackage

// File: rtl/io_seq_timer.sv
module io_seq_timer #(
  parameter int CNT_W = 9
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clear_i,
  input  logic [CNT_W-1:0] limit_i,
  output logic             hit_o
);
  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                 cnt_q <= '0;
    else if (clear_i)           cnt_q <= '0;
    else if (cnt_q != '1)       cnt_q <= cnt_q + 1'b1;
  end

  assign hit_o = (cnt_q == limit_i);
endmodule

// File: rtl/io_seq_result.sv
module io_seq_result #(
  parameter int CC_W   = 3,
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ack_i,
  input  logic              timeout_i,
  input  logic              write_i,
  input  logic [CC_W-1:0]   cc_in_i,
  input  logic [DATA_W-1:0] data_in_i,
  output logic [CC_W-1:0]   cc_o,
  output logic [DATA_W-1:0] data_o
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cc_o   <= '0;
      data_o <= '0;
    end else if (ack_i) begin
      cc_o   <= cc_in_i;
      data_o <= write_i ? '0 : data_in_i;
    end else if (timeout_i) begin
      cc_o   <= '0;   // condition code 0: nobody answered
      data_o <= '0;
    end
  end
endmodule

// File: rtl/io_cmd_sequencer.sv
module io_cmd_sequencer
  import io_seq_pkg::*;
#(
  parameter int DEV_W              = 8,
  parameter int CMD_W              = 8,
  parameter int DATA_W             = 16,
  parameter int CC_W               = 3,
  parameter int CLK_PERIOD_NS      = 8,
  parameter int DESKEW_NS          = 200,
  parameter int RESP_LIMIT_NS      = 3000,
  parameter int TIMEOUT_MARGIN_CYC = 4,
  parameter int STROBE_CYC         = 3
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   start_i,
  input  logic                   write_i,
  input  logic [DEV_W-1:0]       dev_addr_i,
  input  logic [CMD_W-1:0]       cmd_i,
  input  logic [DATA_W-1:0]      wdata_i,
  output logic                   done_o,
  output logic [CC_W-1:0]        cc_o,
  output logic [DATA_W-1:0]      rdata_o,
  output logic [CMD_W+DEV_W-1:0] bus_addr_o,
  output logic                   bus_sel_o,
  output logic [DATA_W-1:0]      bus_wdata_o,
  output logic                   bus_wdata_oe_o,
  output logic                   gate_o,
  input  logic                   gate_ret_i,
  output logic                   strobe_o,
  input  logic [CC_W-1:0]        cc_in_i,
  input  logic [DATA_W-1:0]      rdata_in_i
);
  localparam int DESKEW_CYC  = ns_to_cycles(DESKEW_NS, CLK_PERIOD_NS);
  localparam int TIMEOUT_CYC = ns_to_cycles(RESP_LIMIT_NS, CLK_PERIOD_NS) + TIMEOUT_MARGIN_CYC;
  localparam int CNT_W       = $clog2(max3(DESKEW_CYC, TIMEOUT_CYC, STROBE_CYC) + 1);
  localparam int ADDR_W      = CMD_W + DEV_W;

  seq_state_t state_q, state_d;
  logic [CNT_W-1:0]  limit;
  logic              hit;
  logic              tmr_clear;
  logic [ADDR_W-1:0] addr_q;
  logic [DATA_W-1:0] wdata_q;
  logic              write_q;
  logic              accept;

  // Named internal events, brought out for the checker.
  logic ack_evt;
  logic timeout_evt;

  assign accept      = (state_q == ST_IDLE) && start_i;
  assign ack_evt     = (state_q == ST_GATE) && gate_ret_i;
  assign timeout_evt = (state_q == ST_GATE) && !gate_ret_i && hit;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE:    if (start_i)     state_d = ST_SETUP;
      ST_SETUP:   if (hit)         state_d = ST_GATE;
      ST_GATE:    if (gate_ret_i)  state_d = ST_STROBE;
                  else if (hit)    state_d = ST_ABORT;
      ST_STROBE:  if (hit)         state_d = ST_RELEASE;
      ST_RELEASE: if (!gate_ret_i) state_d = ST_FINISH;
      ST_ABORT:                    state_d = ST_FINISH;
      ST_FINISH:                   state_d = ST_IDLE;
      default:                     state_d = ST_IDLE;
    endcase
  end

  always_comb begin
    unique case (state_q)
      ST_SETUP:  limit = CNT_W'(DESKEW_CYC - 1);
      ST_GATE:   limit = CNT_W'(TIMEOUT_CYC - 1);
      ST_STROBE: limit = CNT_W'(STROBE_CYC - 1);
      default:   limit = '0;
    endcase
  end

  assign tmr_clear = (state_d != state_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      addr_q  <= '0;
      wdata_q <= '0;
      write_q <= 1'b0;
    end else begin
      state_q <= state_d;
      if (accept) begin
        addr_q  <= {cmd_i, dev_addr_i};
        wdata_q <= wdata_i;
        write_q <= write_i;
      end
    end
  end

  io_seq_timer #(.CNT_W(CNT_W)) u_timer (
    .clk     (clk),
    .rst_n   (rst_n),
    .clear_i (tmr_clear),
    .limit_i (limit),
    .hit_o   (hit)
  );

  io_seq_result #(.CC_W(CC_W), .DATA_W(DATA_W)) u_result (
    .clk       (clk),
    .rst_n     (rst_n),
    .ack_i     (ack_evt),
    .timeout_i (timeout_evt),
    .write_i   (write_q),
    .cc_in_i   (cc_in_i),
    .data_in_i (rdata_in_i),
    .cc_o      (cc_o),
    .data_o    (rdata_o)
  );

  assign bus_sel_o      = (state_q != ST_IDLE) && (state_q != ST_FINISH);
  assign bus_addr_o     = bus_sel_o ? addr_q : '0;
  assign bus_wdata_oe_o = bus_sel_o && write_q;
  assign bus_wdata_o    = bus_wdata_oe_o ? wdata_q : '0;
  assign gate_o         = (state_q == ST_GATE) || (state_q == ST_STROBE);
  assign strobe_o       = (state_q == ST_STROBE);
  assign done_o         = (state_q == ST_FINISH);
endmodule

// File: rtl/io_cmd_sequencer_checker.sv
module io_cmd_sequencer_checker #(
  parameter int CC_W        = 3,
  parameter int DESKEW_CYC  = 25,
  parameter int TIMEOUT_CYC = 379,
  parameter int STROBE_CYC  = 3
) (
  input logic            clk,
  input logic            rst_n,
  input logic            sel,
  input logic            gate,
  input logic            strobe,
  input logic            done,
  input logic            gate_ret,
  input logic [CC_W-1:0] cc_in,
  input logic [CC_W-1:0] cc,
  input logic            ack_evt,
  input logic            timeout_evt
);
  int sel_run;
  int wait_run;
  int strobe_run;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sel_run    <= 0;
      wait_run   <= 0;
      strobe_run <= 0;
    end else begin
      sel_run    <= sel ? sel_run + 1 : 0;
      wait_run   <= (gate && !strobe) ? wait_run + 1 : 0;
      strobe_run <= strobe ? strobe_run + 1 : 0;
    end
  end

  p_gate_inside_sel_r1: assert property (@(posedge clk) disable iff (!rst_n)
    gate |-> sel);
  p_deskew_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(gate) |-> (sel_run >= DESKEW_CYC));
  p_wait_bounded_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (gate && !strobe) |-> (wait_run < TIMEOUT_CYC));
  p_timeout_cc0_r4: assert property (@(posedge clk) disable iff (!rst_n)
    timeout_evt |=> (cc == '0));
  p_timeout_no_strobe_r5: assert property (@(posedge clk) disable iff (!rst_n)
    timeout_evt |=> (!strobe && !gate && sel));
  p_gate_before_bus_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(sel) |-> !$past(gate));
  p_capture_cc_r6: assert property (@(posedge clk) disable iff (!rst_n)
    ack_evt |=> (cc == $past(cc_in)));
  p_strobe_in_gate_r7: assert property (@(posedge clk) disable iff (!rst_n)
    strobe |-> gate);
  p_strobe_width_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(strobe) |-> (strobe_run == STROBE_CYC));
  p_hold_until_ret_low_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(sel) |-> !$past(gate_ret));
  p_done_single_r9: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  p_done_after_release_r9: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(sel) |-> done);
endmodule

bind io_cmd_sequencer io_cmd_sequencer_checker #(
  .CC_W        (CC_W),
  .DESKEW_CYC  (DESKEW_CYC),
  .TIMEOUT_CYC (TIMEOUT_CYC),
  .STROBE_CYC  (STROBE_CYC)
) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .sel         (bus_sel_o),
  .gate        (gate_o),
  .strobe      (strobe_o),
  .done        (done_o),
  .gate_ret    (gate_ret_i),
  .cc_in       (cc_in_i),
  .cc          (cc_o),
  .ack_evt     (ack_evt),
  .timeout_evt (timeout_evt)
);

// File: tb/io_cmd_sequencer_bench.sv
module io_cmd_sequencer_bench;
  localparam int PERIOD_NS = 8;
  localparam int STROBE_N  = 3;
  localparam int MARGIN_N  = 4;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start_i = 1'b0;
  logic        write_i = 1'b0;
  logic [7:0]  dev_addr_i = '0;
  logic [7:0]  cmd_i = '0;
  logic [15:0] wdata_i = '0;
  logic        done_o;
  logic [2:0]  cc_o;
  logic [15:0] rdata_o;
  logic [15:0] bus_addr_o;
  logic        bus_sel_o;
  logic [15:0] bus_wdata_o;
  logic        bus_wdata_oe_o;
  logic        gate_o;
  logic        gate_ret_i = 1'b0;
  logic        strobe_o;
  logic [2:0]  cc_in_i = '0;
  logic [15:0] rdata_in_i = '0;

  int checks = 0;
  int errors = 0;
  int cycles = 0;
  bit finished = 1'b0;

  // Device model controls
  int dev_resp = 1;
  int dev_hold = 1;
  int hi_cnt = 0;
  int lo_cnt = 0;

  // Expected counts, found by stepping rather than dividing
  int exp_d;
  int exp_t;

  always #4 clk = ~clk;   // 125 MHz

  io_cmd_sequencer u_io_cmd_sequencer (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .write_i(write_i),
    .dev_addr_i(dev_addr_i), .cmd_i(cmd_i), .wdata_i(wdata_i),
    .done_o(done_o), .cc_o(cc_o), .rdata_o(rdata_o),
    .bus_addr_o(bus_addr_o), .bus_sel_o(bus_sel_o),
    .bus_wdata_o(bus_wdata_o), .bus_wdata_oe_o(bus_wdata_oe_o),
    .gate_o(gate_o), .gate_ret_i(gate_ret_i), .strobe_o(strobe_o),
    .cc_in_i(cc_in_i), .rdata_in_i(rdata_in_i)
  );

  // Device: answers after dev_resp gate-high samples, drops after dev_hold gate-low samples.
  always @(negedge clk) begin
    if (!rst_n) begin
      gate_ret_i <= 1'b0; hi_cnt <= 0; lo_cnt <= 0;
    end else if (gate_o) begin
      lo_cnt <= 0;
      hi_cnt <= hi_cnt + 1;
      if (hi_cnt + 1 >= dev_resp) gate_ret_i <= 1'b1;
    end else begin
      hi_cnt <= 0;
      if (gate_ret_i) begin
        lo_cnt <= lo_cnt + 1;
        if (lo_cnt + 1 >= dev_hold) gate_ret_i <= 1'b0;
      end
    end
  end

  task automatic chk(input string req, input string what, input longint act, input longint exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d at %0t", req, what, act, exp, $time);
    end
  endtask

  // One sequence, compared against its expected timeline on every clock.
  task automatic run_seq(input bit wr, input logic [7:0] dev, input logic [7:0] cmd,
                         input logic [15:0] wd, input int resp, input int hold,
                         input logic [2:0] ccv, input logic [15:0] rdv, input bit stray);
    bit ok;
    int fin, g_end, s_beg;
    logic [15:0] exp_addr;
    ok = (resp <= exp_t);
    s_beg = exp_d + resp + 1;
    g_end = ok ? exp_d + resp + STROBE_N : exp_d + exp_t;
    fin   = ok ? exp_d + resp + STROBE_N + hold + 1 : exp_d + exp_t + 2;
    exp_addr = {cmd, dev};
    dev_resp = resp; dev_hold = hold; cc_in_i = ccv; rdata_in_i = rdv;
    @(negedge clk);
    write_i = wr; dev_addr_i = dev; cmd_i = cmd; wdata_i = wd; start_i = 1'b1;
    for (int j = 1; j <= fin + 1; j++) begin
      @(negedge clk);
      if (j == 1) start_i = 1'b0;
      chk("R1", "sel", bus_sel_o, (j < fin));
      chk("R1", "addr", bus_addr_o, (j < fin) ? exp_addr : 16'h0);
      chk("R12", "wdata_oe", bus_wdata_oe_o, (j < fin) && wr);
      chk("R12", "wdata", bus_wdata_o, ((j < fin) && wr) ? wd : 16'h0);
      chk(ok ? "R2" : "R5", "gate", gate_o, (j >= exp_d + 1) && (j <= g_end));
      chk(ok ? "R7" : "R5", "strobe", strobe_o, ok && (j >= s_beg) && (j <= g_end));
      chk(ok ? "R8" : "R9", "done", done_o, (j == fin));
      if (j == fin) begin
        chk(ok ? "R6" : "R4", "cc", cc_o, ok ? ccv : 3'd0);
        chk(ok ? "R6" : "R4", "rdata", rdata_o, (ok && !wr) ? rdv : 16'h0);
      end
      if (stray && j == 3) begin   // R10: a start in mid-sequence must be ignored
        start_i = 1'b1; write_i = ~wr; dev_addr_i = ~dev; cmd_i = ~cmd; wdata_i = ~wd;
      end
      if (stray && j == 4) start_i = 1'b0;
    end
  endtask

  initial begin
    exp_d = 0;
    while (exp_d * PERIOD_NS < 200) exp_d++;
    exp_t = 0;
    while (exp_t * PERIOD_NS < 3000) exp_t++;
    exp_t = exp_t + MARGIN_N;

    repeat (3) @(negedge clk);
    // R11: reset state
    chk("R11", "sel", bus_sel_o, 0);
    chk("R11", "gate", gate_o, 0);
    chk("R11", "strobe", strobe_o, 0);
    chk("R11", "done", done_o, 0);
    chk("R11", "cc", cc_o, 0);
    chk("R11", "rdata", rdata_o, 0);
    chk("R11", "oe", bus_wdata_oe_o, 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);

    run_seq(1'b0, 8'h21, 8'h5A, 16'h0000, 1, 1, 3'd2, 16'hBEEF, 1'b0);        // R6 quick read
    run_seq(1'b1, 8'h7E, 8'hC3, 16'h1234, 5, 3, 3'd7, 16'hFFFF, 1'b1);        // R12, R10 write with stray start
    run_seq(1'b0, 8'h03, 8'h81, 16'h0000, exp_t, 2, 3'd5, 16'hA5A5, 1'b0);    // R3 answer in last cycle
    run_seq(1'b0, 8'h44, 8'h10, 16'h0000, exp_t + 1, 1, 3'd6, 16'h5555, 1'b0);// R3, R4 one cycle late
    run_seq(1'b1, 8'hFF, 8'h02, 16'hCAFE, 100000, 1, 3'd3, 16'h0F0F, 1'b1);   // R5 absent device on write
    run_seq(1'b0, 8'h10, 8'hEE, 16'h0000, 10, 6, 3'd1, 16'h8001, 1'b0);       // R8 long hold of return

    finished = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000 && !finished) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual %0d cycles expected completion", cycles);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule